// File: doc/BRIEF.md
# Four-Stage In-Order Pipelined Core with Interlock and Forwarding

This block is a small in-order processor core with four pipeline stages. Stage one fetches an instruction word at the program counter. Stage two decodes it and forms the effective data address. Stage three reads the operand from data memory or from the registers. Stage four executes the instruction, writes the result back and resolves branches. Instruction and data storage are two separate internal arrays, so a fetch and a data access never compete for one port. The core has eight general registers and a five-instruction set: load immediate, load through a base register, add, store through a base register, and branch-if-zero.

Results move between instructions without extra cycles where the datapath allows it. The executing instruction's result is forwarded to the address adder and to the operand readers. A store in execute is forwarded to a load from the same address in the operand stage. The one case that cannot be served this way is a load or store whose base register is being produced by the instruction directly ahead of it in the operand stage. That case stalls for one cycle. A taken branch discards everything fetched behind it. Instruction memory is written through a load port while the core is held in reset. The core exposes its program counter, a retire strobe and a register read tap so that a test environment can observe it.

Top module: `pipe4_core`

## Requirements
- R1: While reset is high and on the first cycle after it, the program counter reads 0, `retire_o` is low and every register reads 0 through the tap. Data memory also clears to 0 on reset.
- R2: The instruction word is 16 bits with the opcode in [15:13]: 1 = load immediate (rd[12:10] gets imm[7:0]), 2 = load (rd gets mem[rs+off]), 3 = store (mem[rs+off] gets the register named in [12:10]), 4 = add (rd gets rs+rt, modulo 2^DATA_W), 5 = branch-if-zero (if rs is 0, the next PC is off). rs is [9:7], rt is [6:4] and off is [6:0]. Data addresses wrap to the data memory size. Opcodes 0, 6 and 7 change no state.
- R3: Independent instructions retire one per cycle. Instruction 0 retires on the third clock edge after reset is released.
- R4: A load or store in decode whose base register is the destination of the instruction in the operand stage is held for exactly one cycle. Fetch and decode keep their contents and a bubble enters the operand stage.
- R5: A result in the execute stage is forwarded to the effective-address adder and to both operand readers, so an instruction that directly follows its producer in those stages is not delayed.
- R6: A load in the operand stage reads the data of a store in execute when both use the same address.
- R7: A taken branch resolves in execute. It discards the three younger instructions, and fetch continues at the target on the next cycle, so the target retires four cycles after the branch.
- R8: A branch whose register is nonzero adds no bubble and the next sequential instruction executes.
- R9: `retire_o` is high for exactly one cycle for each instruction that reaches execute, and never for a bubble.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Instruction memory write enable |
| prog_addr | input | PC_W | Instruction memory write address |
| prog_data | input | 16 | Instruction word to write |
| dbg_sel | input | 3 | Register index for the read tap |
| dbg_data | output | DATA_W | Contents of the selected register |
| pc_o | output | PC_W | Current fetch address |
| retire_o | output | 1 | One pulse per instruction leaving execute |

## Verification
The hardest situations to reach from the ports are those where several hazards meet in a few cycles. Examples are a base-register stall directly behind a store that forwards into a following load, and a branch whose squash lands on instructions that would otherwise have stalled or forwarded. Directed programs place producers and consumers at exact distances and check the retire cycle numbers, which show every bubble. Random programs with only forward branches are then compared register by register with an instruction-level model in the bench. This brings about many mixed hazard overlaps that are hard to list by hand.

// File: rtl/p4_pkg.sv
package p4_pkg;
    localparam int INSTR_W = 16;
    localparam int RIDX_W  = 3;
    localparam int NREG    = 8;

    typedef enum logic [2:0] {
        OP_NOP  = 3'd0,
        OP_LI   = 3'd1,
        OP_LD   = 3'd2,
        OP_ST   = 3'd3,
        OP_ADD  = 3'd4,
        OP_BZ   = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [RIDX_W-1:0] rd;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [7:0]        imm;
        logic [6:0]        off;
    } ctl_t;

    function automatic ctl_t decode(input logic [INSTR_W-1:0] w);
        ctl_t c;
        c.op  = op_e'(w[15:13]);
        c.rd  = w[12:10];
        c.rs  = w[9:7];
        c.rt  = w[6:4];
        c.imm = w[7:0];
        c.off = w[6:0];
        return c;
    endfunction

    function automatic logic writes_reg(input op_e op);
        return (op == OP_LI) || (op == OP_LD) || (op == OP_ADD);
    endfunction

    function automatic logic uses_base(input op_e op);
        return (op == OP_LD) || (op == OP_ST);
    endfunction

    // second register operand: store data comes from the rd field
    function automatic logic [RIDX_W-1:0] src2_of(input ctl_t c);
        return (c.op == OP_ST) ? c.rd : c.rt;
    endfunction
endpackage

// File: rtl/p4_ram.sv
module p4_ram #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    parameter bit CLEAR = 1'b0,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    if (CLEAR) begin : g_clr
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            end else if (we) begin
                mem[waddr] <= wdata;
            end
        end
    end else begin : g_plain
        logic unused_rst;
        assign unused_rst = rst;
        always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/p4_regfile.sv
module p4_regfile
    import p4_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NRD    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [RIDX_W-1:0] raddr [NRD],
    output logic [DATA_W-1:0] rdata [NRD]
);
    logic [DATA_W-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = regs_q[raddr[g]];
    end
endmodule

// File: rtl/p4_hazard.sv
module p4_hazard
    import p4_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DA_W   = 4
) (
    input  logic              da_vld,
    input  op_e               da_op,
    input  logic [RIDX_W-1:0] da_rs,
    input  logic              fo_vld,
    input  op_e               fo_op,
    input  logic [RIDX_W-1:0] fo_rd,
    input  logic [RIDX_W-1:0] fo_rs,
    input  logic [RIDX_W-1:0] fo_src2,
    input  logic [DA_W-1:0]   fo_ea,
    input  logic              ex_vld,
    input  op_e               ex_op,
    input  logic [RIDX_W-1:0] ex_rd,
    input  logic [DATA_W-1:0] ex_res,
    input  logic [DATA_W-1:0] ex_stv,
    input  logic [DA_W-1:0]   ex_ea,
    input  logic [DATA_W-1:0] rf_base,
    input  logic [DATA_W-1:0] rf_rs,
    input  logic [DATA_W-1:0] rf_src2,
    input  logic [DATA_W-1:0] mem_rd,
    output logic              stall,
    output logic [DATA_W-1:0] base_v,
    output logic [DATA_W-1:0] rs_v,
    output logic [DATA_W-1:0] src2_v,
    output logic [DATA_W-1:0] mem_v
);
    logic ex_wr;
    assign ex_wr = ex_vld && writes_reg(ex_op);

    function automatic logic [DATA_W-1:0] pick(input logic [RIDX_W-1:0] idx,
                                               input logic [DATA_W-1:0] rf);
        return (ex_wr && ex_rd == idx) ? ex_res : rf;
    endfunction

    // base register produced by the operand-stage instruction is not yet available
    assign stall  = da_vld && uses_base(da_op) && fo_vld && writes_reg(fo_op) && (fo_rd == da_rs);
    assign base_v = pick(da_rs, rf_base);
    assign rs_v   = pick(fo_rs, rf_rs);
    assign src2_v = pick(fo_src2, rf_src2);
    assign mem_v  = (ex_vld && ex_op == OP_ST && fo_vld && fo_op == OP_LD && ex_ea == fo_ea)
                    ? ex_stv : mem_rd;
endmodule

// File: rtl/pipe4_core.sv
module pipe4_core
    import p4_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          prog_we,
    input  logic [$clog2(IMEM_DEPTH)-1:0] prog_addr,
    input  logic [INSTR_W-1:0]            prog_data,
    input  logic [RIDX_W-1:0]             dbg_sel,
    output logic [DATA_W-1:0]             dbg_data,
    output logic [$clog2(IMEM_DEPTH)-1:0] pc_o,
    output logic                          retire_o
);
    localparam int PC_W = $clog2(IMEM_DEPTH);
    localparam int DA_W = $clog2(DMEM_DEPTH);

    // stage state
    logic [PC_W-1:0]    pc_q;
    logic               da_vld_q;
    logic [INSTR_W-1:0] da_ir_q;
    logic               fo_vld_q;
    ctl_t               fo_ctl_q;
    logic [DA_W-1:0]    fo_ea_q;
    logic               ex_vld_q;
    ctl_t               ex_ctl_q;
    logic [DA_W-1:0]    ex_ea_q;
    logic [DATA_W-1:0]  ex_a_q, ex_b_q;

    ctl_t               da_ctl;
    logic [INSTR_W-1:0] fetch_w;
    logic [DATA_W-1:0]  mem_rd, ex_res, base_v, rs_v, src2_v, mem_v, ea_full, fo_a;
    logic               stall, take;
    logic [PC_W-1:0]    br_target;
    logic [RIDX_W-1:0]  rf_ra [4];
    logic [DATA_W-1:0]  rf_rd [4];

    assign da_ctl = decode(da_ir_q);

    p4_ram #(.DEPTH(IMEM_DEPTH), .WIDTH(INSTR_W), .CLEAR(1'b0)) u_imem (
        .clk(clk), .rst(rst), .we(prog_we), .waddr(prog_addr), .wdata(prog_data),
        .raddr(pc_q), .rdata(fetch_w));

    p4_ram #(.DEPTH(DMEM_DEPTH), .WIDTH(DATA_W), .CLEAR(1'b1)) u_dmem (
        .clk(clk), .rst(rst), .we(ex_vld_q && ex_ctl_q.op == OP_ST), .waddr(ex_ea_q),
        .wdata(ex_b_q), .raddr(fo_ea_q), .rdata(mem_rd));

    assign rf_ra[0] = da_ctl.rs;
    assign rf_ra[1] = fo_ctl_q.rs;
    assign rf_ra[2] = src2_of(fo_ctl_q);
    assign rf_ra[3] = dbg_sel;

    p4_regfile #(.DATA_W(DATA_W), .NRD(4)) u_rf (
        .clk(clk), .rst(rst), .we(ex_vld_q && writes_reg(ex_ctl_q.op)),
        .waddr(ex_ctl_q.rd), .wdata(ex_res), .raddr(rf_ra), .rdata(rf_rd));

    p4_hazard #(.DATA_W(DATA_W), .DA_W(DA_W)) u_hz (
        .da_vld(da_vld_q), .da_op(da_ctl.op), .da_rs(da_ctl.rs),
        .fo_vld(fo_vld_q), .fo_op(fo_ctl_q.op), .fo_rd(fo_ctl_q.rd), .fo_rs(fo_ctl_q.rs),
        .fo_src2(src2_of(fo_ctl_q)), .fo_ea(fo_ea_q),
        .ex_vld(ex_vld_q), .ex_op(ex_ctl_q.op), .ex_rd(ex_ctl_q.rd), .ex_res(ex_res),
        .ex_stv(ex_b_q), .ex_ea(ex_ea_q),
        .rf_base(rf_rd[0]), .rf_rs(rf_rd[1]), .rf_src2(rf_rd[2]), .mem_rd(mem_rd),
        .stall(stall), .base_v(base_v), .rs_v(rs_v), .src2_v(src2_v), .mem_v(mem_v));

    // decode stage: effective address from the (possibly forwarded) base
    assign ea_full = base_v + DATA_W'(da_ctl.off);
    // operand stage: loads take memory data, everything else the rs register
    assign fo_a = (fo_ctl_q.op == OP_LD) ? mem_v : rs_v;

    // execute stage
    always_comb begin
        case (ex_ctl_q.op)
            OP_ADD:  ex_res = ex_a_q + ex_b_q;
            OP_LI:   ex_res = DATA_W'(ex_ctl_q.imm);
            default: ex_res = ex_a_q;
        endcase
    end
    assign take      = ex_vld_q && ex_ctl_q.op == OP_BZ && ex_a_q == '0;
    assign br_target = PC_W'(ex_ctl_q.off);

    logic unused_bits;
    assign unused_bits = ^{ea_full, ex_ctl_q.rs, ex_ctl_q.rt};

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q     <= '0;
            da_vld_q <= 1'b0;
            fo_vld_q <= 1'b0;
            ex_vld_q <= 1'b0;
        end else if (take) begin
            pc_q     <= br_target;
            da_vld_q <= 1'b0;
            fo_vld_q <= 1'b0;
            ex_vld_q <= 1'b0;
        end else begin
            ex_vld_q <= fo_vld_q;
            ex_ctl_q <= fo_ctl_q;
            ex_ea_q  <= fo_ea_q;
            ex_a_q   <= fo_a;
            ex_b_q   <= src2_v;
            if (stall) begin
                fo_vld_q <= 1'b0;
            end else begin
                fo_vld_q <= da_vld_q;
                fo_ctl_q <= da_ctl;
                fo_ea_q  <= ea_full[DA_W-1:0];
                da_vld_q <= 1'b1;
                da_ir_q  <= fetch_w;
                pc_q     <= pc_q + 1'b1;
            end
        end
    end

    assign pc_o     = pc_q;
    assign retire_o = ex_vld_q;
    assign dbg_data = rf_rd[3];

    // R1: the first cycle after reset sees an empty pipeline at address zero
    a_r1_reset_empty: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc_q == '0 && !da_vld_q && !fo_vld_q && !ex_vld_q));

    // R3: with no stall and no redirect, fetch advances by one
    a_r3_pc_step: assert property (@(posedge clk) disable iff (rst)
        (!stall && !take) |=> (pc_q == PC_W'($past(pc_q) + 1'b1)));

    // R4: an interlock freezes fetch and decode and sends a bubble onward
    a_r4_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (stall && !take) |=> (pc_q == $past(pc_q) && da_ir_q == $past(da_ir_q)
                              && da_vld_q && !fo_vld_q));

    // R7: a taken branch empties the three younger stages and redirects fetch
    a_r7_squash: assert property (@(posedge clk) disable iff (rst)
        take |=> (!da_vld_q && !fo_vld_q && !ex_vld_q && pc_q == $past(br_target)));

    // R9: a bubble made by an interlock never reaches retirement
    a_r9_bubble_no_retire: assert property (@(posedge clk) disable iff (rst)
        (stall && !take) |=> ##1 (!retire_o || $past(take)));
endmodule

// File: tb/tb_pipe4_core.sv
module tb_pipe4_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prog_we = 1'b0;
    logic [6:0]  prog_addr = '0;
    logic [15:0] prog_data = '0;
    logic [2:0]  dbg_sel = '0;
    logic [7:0]  dbg_data;
    logic [6:0]  pc_o;
    logic        retire_o;

    always #4 clk = ~clk;

    pipe4_core #(.DATA_W(8), .IMEM_DEPTH(128), .DMEM_DEPTH(16)) dut (
        .clk(clk), .rst(rst), .prog_we(prog_we), .prog_addr(prog_addr),
        .prog_data(prog_data), .dbg_sel(dbg_sel), .dbg_data(dbg_data),
        .pc_o(pc_o), .retire_o(retire_o));

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    logic [15:0] prog [128];
    int ret_k [64];
    int n_ret;
    int mr [8];
    int mm [16];

    function automatic logic [15:0] e_li(int rd, int imm);
        return {3'd1, 3'(rd), 2'b00, 8'(imm)};
    endfunction
    function automatic logic [15:0] e_ld(int rd, int rs, int off);
        return {3'd2, 3'(rd), 3'(rs), 7'(off)};
    endfunction
    function automatic logic [15:0] e_st(int rsrc, int rs, int off);
        return {3'd3, 3'(rsrc), 3'(rs), 7'(off)};
    endfunction
    function automatic logic [15:0] e_add(int rd, int rs, int rt);
        return {3'd4, 3'(rd), 3'(rs), 3'(rt), 4'b0000};
    endfunction
    function automatic logic [15:0] e_bz(int rs, int tgt);
        return {3'd5, 3'd0, 3'(rs), 7'(tgt)};
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_reg(string tag, int r, int exp);
        dbg_sel = 3'(r);
        #1;
        chk(tag, int'(dbg_data), exp);
    endtask

    task automatic clear_prog();
        for (int a = 0; a < 128; a++) prog[a] = 16'h0000;
    endtask

    task automatic load_reset();
        @(negedge clk);
        rst = 1'b1;
        for (int a = 0; a < 128; a++) begin
            prog_we = 1'b1;
            prog_addr = 7'(a);
            prog_data = prog[a];
            @(negedge clk);
        end
        prog_we = 1'b0;
    endtask

    task automatic run(int n);
        n_ret = 0;
        rst = 1'b0;
        for (int k = 1; k <= n; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (retire_o) begin
                if (n_ret < 64) ret_k[n_ret] = k;
                n_ret++;
            end
        end
    endtask

    // instruction-level reference model
    task automatic model(int plen);
        int pc;
        int steps;
        pc = 0;
        steps = 0;
        for (int i = 0; i < 8; i++) mr[i] = 0;
        for (int i = 0; i < 16; i++) mm[i] = 0;
        while (pc < plen && steps < 1000) begin
            logic [15:0] w;
            int op, rd, rs, rt, off;
            w = prog[pc];
            op = int'(w[15:13]);
            rd = int'(w[12:10]);
            rs = int'(w[9:7]);
            rt = int'(w[6:4]);
            off = int'(w[6:0]);
            steps++;
            pc++;
            case (op)
                1: mr[rd] = int'(w[7:0]);
                2: mr[rd] = mm[(mr[rs] + off) % 16];
                3: mm[(mr[rs] + off) % 16] = mr[rd];
                4: mr[rd] = (mr[rs] + mr[rt]) % 256;
                5: if (mr[rs] == 0) pc = off;
                default: ;
            endcase
        end
    endtask

    function automatic logic [15:0] rand_instr(int idx, int plen);
        int k, a, b, c;
        k = int'($urandom_range(0, 9));
        a = int'($urandom_range(0, 7));
        b = int'($urandom_range(0, 7));
        c = int'($urandom_range(0, 7));
        case (k)
            0, 1, 2: return e_li(a, int'($urandom_range(0, 255)));
            3:       return e_ld(a, b, int'($urandom_range(0, 127)));
            4:       return e_st(a, b, int'($urandom_range(0, 127)));
            5, 6:    return e_add(a, b, c);
            7:       return e_bz(b, int'($urandom_range(plen, idx + 1)));
            8:       return 16'h0000;
            default: return {3'd6, 13'(int'($urandom_range(0, 8191)))};
        endcase
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));

        // ---- directed: forwarding, store-to-load, base interlock ----
        clear_prog();
        prog[0] = e_li(1, 5);
        prog[1] = e_li(2, 8'h3C);
        prog[2] = e_st(2, 1, 0);
        prog[3] = e_ld(3, 1, 0);
        prog[4] = e_li(4, 2);
        prog[5] = e_ld(5, 4, 3);
        prog[6] = e_add(6, 5, 4);
        prog[7] = e_add(7, 6, 6);
        load_reset();
        // R1: state while held in reset
        chk("R1 pc in reset", int'(pc_o), 0);
        chk("R1 retire in reset", int'(retire_o), 0);
        for (int r = 0; r < 8; r++) chk_reg("R1 register cleared", r, 0);
        run(14);
        chk("R3 first retire edge", ret_k[0], 3);
        chk("R5 back-to-back retire", ret_k[3], 6);
        chk("R4 one bubble on base hazard", ret_k[5] - ret_k[4], 2);
        chk("R5 load result forwarded to add", ret_k[6], 10);
        chk("R9 retire count", n_ret, 11);
        chk_reg("R2 load immediate", 1, 5);
        chk_reg("R5 store data forwarded", 2, 8'h3C);
        chk_reg("R6 load sees store in flight", 3, 8'h3C);
        chk_reg("R4 stalled load value", 5, 8'h3C);
        chk_reg("R5 add with forwarded load", 6, 8'h3E);
        chk_reg("R5 add with forwarded add", 7, 8'h7C);

        // ---- directed: taken branch ----
        clear_prog();
        prog[0] = e_li(1, 0);
        prog[1] = e_bz(1, 5);
        prog[2] = e_li(2, 9);
        prog[3] = e_li(3, 9);
        prog[4] = e_li(4, 9);
        prog[5] = e_li(5, 7);
        load_reset();
        run(10);
        chk("R7 branch retire edge", ret_k[1], 4);
        chk("R7 target retires four later", ret_k[2], 8);
        chk("R9 retire count with squash", n_ret, 5);
        chk_reg("R7 squashed r2", 2, 0);
        chk_reg("R7 squashed r3", 3, 0);
        chk_reg("R7 squashed r4", 4, 0);
        chk_reg("R7 target executed", 5, 7);

        // ---- directed: branch not taken ----
        clear_prog();
        prog[0] = e_li(1, 1);
        prog[1] = e_bz(1, 5);
        prog[2] = e_li(2, 9);
        prog[3] = e_li(3, 8);
        load_reset();
        run(8);
        chk("R8 no bubble after untaken branch", ret_k[2], 5);
        chk_reg("R8 fall-through r2", 2, 9);
        chk_reg("R8 fall-through r3", 3, 8);

        // ---- directed: address wrap and reserved opcodes ----
        clear_prog();
        prog[0] = e_li(1, 8'hFE);
        prog[1] = e_li(2, 8'h11);
        prog[2] = e_st(2, 1, 3);
        prog[3] = {3'd7, 13'h1FFF};
        prog[4] = e_ld(3, 0, 1);
        prog[5] = e_add(4, 1, 2);
        load_reset();
        run(12);
        chk_reg("R2 wrapped address store and load", 3, 8'h11);
        chk_reg("R2 add wraps modulo 256", 4, 8'h0F);
        chk_reg("R2 reserved opcode leaves r7", 7, 0);

        // ---- constrained random programs against the model ----
        for (int t = 0; t < 8; t++) begin
            clear_prog();
            for (int i = 0; i < 20; i++) prog[i] = rand_instr(i, 20);
            model(20);
            load_reset();
            run(120);
            for (int r = 0; r < 8; r++) chk_reg("R2 random program register", r, mr[r]);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule